// File: doc/BRIEF.md
# Chainable DMA Channel Engine

A single memory-to-memory copy channel. Software (or another channel) programs a read pointer, a write pointer, a transfer count and a control word. The channel then moves that many items, each as one read beat followed by one write beat on a simple request/acknowledge bus master port. Item size is byte, halfword or word. Each pointer either advances by the item size after every item or stays fixed. One of the two pointers may be confined to a power-of-two ring, so that a table can be replayed from its start without reprogramming.

The pace of the transfers comes from a selectable request source: one of the external data-request lines, one of four pacing-timer pulse lines, or a permanent request that runs unpaced. Writing a non-zero value to the count-and-start register loads the count and starts the channel. On completion the channel emits a one-cycle chain pulse together with the index of the channel it targets. A second input restarts the channel from its stored reload count. Two channels can therefore reload and restart each other in a loop that needs no processor.

Top module: `dma_chan`

## Requirements
- R1: Register offsets: 0 read pointer, 1 write pointer, 2 reload count, 3 count-and-start, 4 control. Control bits: [1:0] size (0 byte, 1 halfword, 2 word), [2] read increment, [3] write increment, [4] ring applies to the write pointer (else the read pointer), [8:5] ring N, [14:9] request select, [18:15] chain-to index. After reset the control word gives word size, read increment on, write increment off, a permanent request, chain-to equal to the channel's own index and ring off. The channel is idle with no bus request.
- R2: A non-zero write to offset 3 loads the remaining count and reload count and makes busy_o high in the next cycle. A zero write there leaves an idle channel idle and issues no beats.
- R3: When the last item's write beat is acknowledged, busy_o falls and chain_o is high for exactly one cycle with chain_idx_o equal to the chain-to field. If chain-to equals the channel's own index, no pulse is produced.
- R4: Each item is a read beat then a write beat of the programmed size (bus_size_o carries the size code). A pointer advances by 1, 2 or 4 bytes per item only when its increment bit is set.
- R5: With ring N non-zero, the selected pointer keeps its bits above N fixed and wraps its low N bits. With N=9, halfword items and a 512-byte aligned base, item 256 reads the base again.
- R6: Request select 0 to NUM_DREQ-1 picks dreq_i of that index, 0x3b to 0x3e picks pace_i[0] to pace_i[3], and 0x3f is a permanent request. Pulses on unselected lines start no item.
- R7: In paced mode one item is issued per selected request pulse. Pulses that arrive while an item is in progress are held and used later.
- R8: A non-zero write to offset 3 while busy replaces the remaining count. The channel completes after that many further items and produces one chain pulse.
- R9: abort_i ends activity: in the next cycle busy_o and bus_req_o are low, the remaining count is cleared, no chain pulse is produced and no further beats occur.
- R10: A pulse on chain_trig_i starts the channel with the reload count when that count is non-zero. A write to offset 2 alone does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| chain_trig_i | input | 1 | Restart from the reload count |
| abort_i | input | 1 | Stop the channel without a chain pulse |
| dreq_i | input | NUM_DREQ | External data-request pulses |
| pace_i | input | 4 | Pacing timer pulses |
| bus_req_o | output | 1 | Bus beat request, held until acknowledged |
| bus_we_o | output | 1 | Beat is a write |
| bus_addr_o | output | 32 | Byte address of the beat |
| bus_size_o | output | 2 | Size code of the beat |
| bus_wdata_o | output | 32 | Write data, right aligned |
| bus_ack_i | input | 1 | Beat acknowledge |
| bus_rdata_i | input | 32 | Read data, right aligned, valid with ack |
| busy_o | output | 1 | Channel active |
| chain_o | output | 1 | One-cycle completion chain pulse |
| chain_idx_o | output | 4 | Index of the channel to start |

## Verification
The bench builds the channel with CHAN_ID=1 and NUM_DREQ=4. The non-zero own index makes the default self-chain distinct from chain targets 5 and 7, so both the suppressed and the emitted pulse can be observed. Four request lines put a selected line (2) and an unselected one (3) within reach. A 4 KiB byte memory model lets a 260-item halfword run cross the 512-byte ring boundary and land on the base again.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int CHAIN_W = 4;
  localparam int SEL_W   = 6;
  localparam int RING_W  = 4;
  localparam int NUM_TMR = 4;

  typedef enum logic [1:0] {XS_8 = 2'd0, XS_16 = 2'd1, XS_32 = 2'd2} xsize_e;

  typedef struct packed {
    logic [CHAIN_W-1:0] chain_to;
    logic [SEL_W-1:0]   req_sel;
    logic [RING_W-1:0]  ring_n;
    logic               ring_wr;
    logic               wr_inc;
    logic               rd_inc;
    xsize_e             size;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [SEL_W-1:0] SEL_TMR0 = 6'h3b;
  localparam logic [SEL_W-1:0] SEL_PERM = 6'h3f;

  typedef enum logic [2:0] {
    RA_RD     = 3'd0,
    RA_WR     = 3'd1,
    RA_CNT    = 3'd2,
    RA_CNT_GO = 3'd3,
    RA_CTRL   = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chain_trig_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] rd_next_i,
  input  logic [ADDR_W-1:0] wr_next_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              start_o,
  output logic [CNT_W-1:0]  start_cnt_o
);
  localparam ctrl_t CTRL_RST = '{
    chain_to: CHAIN_W'(CHAN_ID),
    req_sel:  SEL_PERM,
    ring_n:   '0,
    ring_wr:  1'b0,
    wr_inc:   1'b0,
    rd_inc:   1'b1,
    size:     XS_32
  };

  logic [CNT_W-1:0] reload_q;
  logic             sw_go, hw_go;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  assign sw_go       = we_i && (addr_i == RA_CNT_GO) && (wdata_i[CNT_W-1:0] != '0);
  assign hw_go       = chain_trig_i && (reload_q != '0);
  assign start_o     = sw_go || hw_go;
  assign start_cnt_o = sw_go ? wdata_i[CNT_W-1:0] : reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= CTRL_RST;
      rd_addr_o <= '0;
      wr_addr_o <= '0;
      reload_q  <= '0;
    end else begin
      if (adv_i) begin
        rd_addr_o <= rd_next_i;
        wr_addr_o <= wr_next_i;
      end
      if (we_i) begin
        case (addr_i)
          RA_RD:               rd_addr_o <= wdata_i;
          RA_WR:               wr_addr_o <= wdata_i;
          RA_CNT, RA_CNT_GO:   reload_q  <= wdata_i[CNT_W-1:0];
          RA_CTRL:             ctrl_o    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  xsize_e            size_i,
  input  logic              inc_i,
  input  logic              ring_en_i,
  input  logic [RING_W-1:0] ring_n_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step, sum, mask;

  always_comb begin
    case (size_i)
      XS_8:    step = ADDR_W'(1);
      XS_16:   step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
    if (!inc_i) step = '0;
    sum  = addr_i + step;
    mask = (ADDR_W'(1) << ring_n_i) - ADDR_W'(1);
    if (ring_en_i && ring_n_i != '0)
      next_o = (addr_i & ~mask) | (sum & mask);
    else
      next_o = sum;
  end
endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl
  import dma_pkg::*;
#(
  parameter int NUM_DREQ = 8,
  parameter int PEND_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_DREQ-1:0] dreq_i,
  input  logic [NUM_TMR-1:0]  pace_i,
  input  logic                busy_i,
  input  logic                clear_i,
  input  logic                take_i,
  output logic                avail_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              hit, perm;
  logic [PEND_W-1:0] pend_q;

  always_comb begin
    hit  = 1'b0;
    perm = (sel_i == SEL_PERM);
    for (int t = 0; t < NUM_TMR; t++)
      if (sel_i == SEL_TMR0 + SEL_W'(t)) hit = pace_i[t];
    for (int d = 0; d < NUM_DREQ; d++)
      if (sel_i == SEL_W'(d)) hit = dreq_i[d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (clear_i || !busy_i || perm) begin
      pend_q <= '0;
    end else begin
      case ({hit, take_i})
        2'b10: if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
        2'b01: pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign avail_o = perm || (pend_q != '0);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int CHAN_ID  = 0,
  parameter int NUM_DREQ = 8,
  parameter int CNT_W    = 32,
  parameter int PEND_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  input  logic                chain_trig_i,
  input  logic                abort_i,
  input  logic [NUM_DREQ-1:0] dreq_i,
  input  logic [3:0]          pace_i,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [31:0]         bus_addr_o,
  output logic [1:0]          bus_size_o,
  output logic [31:0]         bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic [31:0]         bus_rdata_i,
  output logic                busy_o,
  output logic                chain_o,
  output logic [3:0]          chain_idx_o
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] rd_addr, wr_addr, rd_next, wr_next;
  logic              start, avail, adv, take;
  logic [CNT_W-1:0]  start_cnt, cnt_q, cnt_d;
  st_e               st_q, st_d;
  logic              chain_q, chain_d;
  logic [DATA_W-1:0] data_q, data_d, rd_fit;

  assign adv  = (st_q == ST_WR) && bus_ack_i && !abort_i;
  assign take = (st_q == ST_WAIT) && avail && !abort_i;

  dma_regs #(.CHAN_ID(CHAN_ID), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .chain_trig_i, .adv_i(adv), .rd_next_i(rd_next), .wr_next_i(wr_next),
    .ctrl_o(ctrl), .rd_addr_o(rd_addr), .wr_addr_o(wr_addr),
    .start_o(start), .start_cnt_o(start_cnt)
  );

  dma_addr_step i_rd_step (
    .addr_i(rd_addr), .size_i(ctrl.size), .inc_i(ctrl.rd_inc),
    .ring_en_i(!ctrl.ring_wr), .ring_n_i(ctrl.ring_n), .next_o(rd_next)
  );

  dma_addr_step i_wr_step (
    .addr_i(wr_addr), .size_i(ctrl.size), .inc_i(ctrl.wr_inc),
    .ring_en_i(ctrl.ring_wr), .ring_n_i(ctrl.ring_n), .next_o(wr_next)
  );

  dma_req_ctl #(.NUM_DREQ(NUM_DREQ), .PEND_W(PEND_W)) i_req (
    .clk_i, .rst_ni,
    .sel_i(ctrl.req_sel), .dreq_i, .pace_i,
    .busy_i(busy_o), .clear_i(start || abort_i), .take_i(take),
    .avail_o(avail)
  );

  always_comb begin
    case (ctrl.size)
      XS_8:    rd_fit = {24'd0, bus_rdata_i[7:0]};
      XS_16:   rd_fit = {16'd0, bus_rdata_i[15:0]};
      default: rd_fit = bus_rdata_i;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    chain_d = 1'b0;
    case (st_q)
      ST_WAIT: if (avail) st_d = ST_RD;
      ST_RD: if (bus_ack_i) begin
        data_d = rd_fit;
        st_d   = ST_WR;
      end
      ST_WR: if (bus_ack_i) begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          st_d    = ST_IDLE;
          chain_d = (ctrl.chain_to != CHAIN_W'(CHAN_ID));
        end else begin
          st_d = ST_WAIT;
        end
      end
      default: ;
    endcase
    // restart reloads the count; an item already on the bus runs on
    if (start) begin
      cnt_d   = start_cnt;
      chain_d = 1'b0;
      if (st_d == ST_IDLE) st_d = ST_WAIT;
    end
    if (abort_i) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      chain_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      chain_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      chain_q <= chain_d;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign bus_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = (st_q == ST_WR) ? wr_addr : rd_addr;
  assign bus_size_o  = ctrl.size;
  assign bus_wdata_o = data_q;
  assign chain_o     = chain_q;
  assign chain_idx_o = ctrl.chain_to;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int CHAN_ID = 0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        chain_trig_i,
  input logic        abort_i,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [31:0] bus_addr_o,
  input logic        bus_ack_i,
  input logic        busy_o,
  input logic        chain_o,
  input logic [3:0]  chain_idx_o
);
  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !abort_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

  p_req_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  p_zero_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 3'd3 && reg_wdata_i == 32'd0 && !busy_o && !chain_trig_i |=> !busy_o);

  p_chain_not_self_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |-> chain_idx_o != 4'(CHAN_ID));

  p_chain_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |=> !chain_o);

  p_chain_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chain_o) |-> $fell(busy_o));

  p_abort_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !bus_req_o && !chain_o);
endmodule

bind dma_chan dma_chan_chk #(.CHAN_ID(CHAN_ID)) i_dma_chan_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .chain_trig_i(chain_trig_i), .abort_i(abort_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_ack_i(bus_ack_i), .busy_o(busy_o),
  .chain_o(chain_o), .chain_idx_o(chain_idx_o)
);

// File: tb/test_dma_chan.sv
module test_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam int NDQ = 4;
  localparam int LOGN = 512;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 0; logic [2:0] reg_addr_i = 0; logic [31:0] reg_wdata_i = 0;
  logic chain_trig_i = 0, abort_i = 0;
  logic [NDQ-1:0] dreq_i = 0; logic [3:0] pace_i = 0;
  logic bus_req_o, bus_we_o, bus_ack_i, busy_o, chain_o;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic [1:0] bus_size_o; logic [3:0] chain_idx_o;

  dma_chan #(.CHAN_ID(1), .NUM_DREQ(NDQ)) i_dma_chan (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [7:0] mem [0:4095];
  logic ack_q;
  int nwr = 0, nrd = 0, chain_cnt = 0, chain_hi = 0, total = 0, bad = 0;
  logic [3:0] chain_last;
  logic chain_prev;
  logic [31:0] wr_a [0:LOGN-1]; logic [31:0] wr_d [0:LOGN-1];
  logic [31:0] rd_a [0:LOGN-1]; logic [1:0] wr_s [0:LOGN-1];
  bit done = 0;

  function automatic logic [7:0] init_b(int a);
    return 8'((a & 12'hfff) * 7 + 3);
  endfunction

  function automatic logic [31:0] exp_word(int a, int s);
    logic [31:0] w;
    w = {init_b(a+3), init_b(a+2), init_b(a+1), init_b(a)};
    if (s == 0) w = w & 32'hff; else if (s == 1) w = w & 32'hffff;
    return w;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {mem[12'(a+3)], mem[12'(a+2)], mem[12'(a+1)], mem[12'(a)]};
  endfunction

  assign bus_ack_i = ack_q;
  assign bus_rdata_i = ack_q ? mem_word(bus_addr_o) : 32'd0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      chain_prev <= 1'b0;
      for (int i = 0; i < 4096; i++) mem[i] <= init_b(i);
    end else begin
      ack_q <= bus_req_o && !ack_q;
      chain_prev <= chain_o;
      if (chain_o) begin chain_hi <= chain_hi + 1; chain_last <= chain_idx_o; end
      if (chain_o && !chain_prev) chain_cnt <= chain_cnt + 1;
      if (ack_q && bus_req_o) begin
        if (bus_we_o) begin
          for (int k = 0; k < (1 << bus_size_o); k++)
            mem[12'(bus_addr_o + 32'(k))] <= bus_wdata_o[8*k +: 8];
          if (nwr < LOGN) begin
            wr_a[nwr] <= bus_addr_o; wr_d[nwr] <= bus_wdata_o; wr_s[nwr] <= bus_size_o;
          end
          nwr <= nwr + 1;
        end else begin
          if (nrd < LOGN) rd_a[nrd] <= bus_addr_o;
          nrd <= nrd + 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  function automatic logic [31:0] mk_ctrl(int sz, int ri, int wi, int rw, int rn, int sel, int ch);
    return 32'(sz) | 32'(ri) << 2 | 32'(wi) << 3 | 32'(rw) << 4 | 32'(rn) << 5
         | 32'(sel) << 9 | 32'(ch) << 15;
  endfunction

  task automatic wait_idle(int maxc);
    for (int i = 0; i < maxc && busy_o; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk_i); endtask

  task automatic pulse_pace(int t);
    @(negedge clk_i); pace_i[t] = 1; @(negedge clk_i); pace_i[t] = 0;
  endtask

  task automatic pulse_dreq(int t);
    @(negedge clk_i); dreq_i[t] = 1; @(negedge clk_i); dreq_i[t] = 0;
  endtask

  task automatic t_reset;
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "bus_req after reset", bus_req_o, 0);
    chk("R1", "chain after reset", chain_o, 0);
  endtask

  task automatic t_defaults;
    int n0 = nwr, r0 = nrd, c0 = chain_cnt;
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC00); wreg(3'd3, 3);
    wait_idle(200);
    chk("R1", "default item count", nwr - n0, 3);
    chk("R1", "default rd inc word", rd_a[r0+2], 32'h108);
    chk("R1", "default wr fixed", wr_a[n0+2], 32'hC00);
    chk("R1", "default size word", wr_s[n0+1], 2);
    chk("R4", "word data", wr_d[n0+2], exp_word(32'h108, 2));
    chk("R3", "self chain no pulse", chain_cnt - c0, 0);
  endtask

  task automatic t_zero_go;
    int n0 = nwr;
    wreg(3'd3, 0); idle(10);
    chk("R2", "zero write busy", busy_o, 0);
    chk("R2", "zero write beats", nwr - n0, 0);
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC10);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = 3'd3; reg_wdata_i = 2;
    @(negedge clk_i); reg_we_i = 0;
    chk("R2", "busy next cycle", busy_o, 1);
    wait_idle(200);
    chk("R2", "nonzero start items", nwr - n0, 2);
  endtask

  task automatic t_size_inc;
    int n0 = nwr, r0 = nrd, c0 = chain_cnt, h0 = chain_hi;
    wreg(3'd4, mk_ctrl(0, 0, 1, 0, 0, 6'h3f, 5));
    wreg(3'd0, 32'h200); wreg(3'd1, 32'hD00); wreg(3'd3, 4);
    wait_idle(200);
    chk("R4", "byte items", nwr - n0, 4);
    chk("R4", "rd fixed", rd_a[r0+3], 32'h200);
    chk("R4", "wr byte step", wr_a[n0+3], 32'hD03);
    chk("R4", "byte size code", wr_s[n0], 0);
    chk("R4", "byte data", wr_d[n0+1], exp_word(32'h200, 0));
    chk("R3", "chain pulse count", chain_cnt - c0, 1);
    chk("R3", "chain one cycle", chain_hi - h0, 1);
    chk("R3", "chain idx", chain_last, 5);
    chk("R3", "busy low at end", busy_o, 0);
  endtask

  task automatic t_ring_rd;
    int n0 = nwr, r0 = nrd;
    wreg(3'd4, mk_ctrl(1, 1, 0, 0, 9, 6'h3f, 1));
    wreg(3'd0, 32'h800); wreg(3'd1, 32'hE00); wreg(3'd3, 260);
    wait_idle(5000);
    chk("R5", "ring items", nwr - n0, 260);
    chk("R5", "ring last before wrap", rd_a[r0+255], 32'h9FE);
    chk("R5", "ring wraps to base", rd_a[r0+256], 32'h800);
    chk("R5", "ring after wrap", rd_a[r0+259], 32'h806);
    chk("R5", "ring replay data", wr_d[n0+256], exp_word(32'h800, 1));
    chk("R4", "half size code", wr_s[n0], 1);
  endtask

  task automatic t_ring_wr;
    int n0 = nwr;
    wreg(3'd4, mk_ctrl(0, 0, 1, 1, 2, 6'h3f, 1));
    wreg(3'd0, 32'h300); wreg(3'd1, 32'hF00); wreg(3'd3, 6);
    wait_idle(200);
    chk("R5", "wr ring item 3", wr_a[n0+3], 32'hF03);
    chk("R5", "wr ring wraps", wr_a[n0+4], 32'hF00);
    chk("R5", "wr ring item 5", wr_a[n0+5], 32'hF01);
  endtask

  task automatic t_paced;
    int n0 = nwr, c0 = chain_cnt;
    wreg(3'd4, mk_ctrl(2, 1, 0, 0, 0, 6'h3c, 7));
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC40); wreg(3'd3, 3);
    idle(20);
    chk("R7", "no request no item", nwr - n0, 0);
    chk("R7", "waiting busy", busy_o, 1);
    pulse_pace(0); idle(20);
    chk("R6", "unselected timer ignored", nwr - n0, 0);
    @(negedge clk_i); pace_i[1] = 1; idle(3); pace_i[1] = 0;
    wait_idle(200);
    chk("R7", "back to back pulses all used", nwr - n0, 3);
    chk("R3", "paced chain", chain_cnt - c0, 1);
    chk("R3", "paced chain idx", chain_last, 7);
  endtask

  task automatic t_dreq;
    int n0 = nwr;
    wreg(3'd4, mk_ctrl(2, 1, 0, 0, 0, 2, 7));
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC50); wreg(3'd3, 2);
    pulse_dreq(3); idle(20);
    chk("R6", "other dreq ignored", nwr - n0, 0);
    pulse_dreq(2); idle(15);
    chk("R6", "one dreq one item", nwr - n0, 1);
    pulse_dreq(2); wait_idle(200);
    chk("R6", "dreq items", nwr - n0, 2);
    chk("R6", "dreq done", busy_o, 0);
  endtask

  task automatic t_restart;
    int n0 = nwr, c0 = chain_cnt;
    wreg(3'd4, mk_ctrl(2, 1, 0, 0, 0, 6'h3b, 7));
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC60); wreg(3'd3, 5);
    pulse_pace(0); idle(15); pulse_pace(0); idle(15);
    chk("R8", "items before restart", nwr - n0, 2);
    wreg(3'd3, 2);
    for (int i = 0; i < 4; i++) begin pulse_pace(0); idle(15); end
    wait_idle(200);
    chk("R8", "items after restart", nwr - n0, 4);
    chk("R8", "restart chain once", chain_cnt - c0, 1);
    chk("R8", "restart done", busy_o, 0);
  endtask

  task automatic t_abort;
    int n0, c0 = chain_cnt;
    wreg(3'd4, mk_ctrl(2, 1, 0, 0, 0, 6'h3f, 7));
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC70); wreg(3'd3, 100);
    idle(30);
    @(negedge clk_i); abort_i = 1; @(negedge clk_i); abort_i = 0;
    chk("R9", "busy after abort", busy_o, 0);
    chk("R9", "bus_req after abort", bus_req_o, 0);
    n0 = nwr; idle(20);
    chk("R9", "no beats after abort", nwr - n0, 0);
    chk("R9", "no chain on abort", chain_cnt - c0, 0);
  endtask

  task automatic t_chain_in;
    int n0 = nwr, c0 = chain_cnt;
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hC80); wreg(3'd2, 3);
    idle(5);
    chk("R10", "reload write no start", busy_o, 0);
    @(negedge clk_i); chain_trig_i = 1; @(negedge clk_i); chain_trig_i = 0;
    chk("R10", "chain input starts", busy_o, 1);
    wait_idle(200);
    chk("R10", "reload items", nwr - n0, 3);
    chk("R10", "chain after reload run", chain_cnt - c0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1;
    idle(2);
    t_defaults();
    t_zero_go();
    t_size_inc();
    t_ring_rd();
    t_ring_wr();
    t_paced();
    t_dreq();
    t_restart();
    t_abort();
    t_chain_in();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule